// File: doc/BRIEF.md
# Serial Test-Port Program Command Receiver

This block receives commands on a three-wire serial test port made of a data line, a test clock and an enable line. A further activation input must be high for the port to respond at all. While enable is high, the block samples one bit on every rising edge of the test clock. The first six bits form a command code. The code 0x04 selects the memory-write command. Any other code makes the block ignore the port until enable falls.

After a write code, the block collects a data nibble, then a row address, then a nibble-select address. Every field arrives least significant bit first. The assembled fields then appear on parallel outputs, together with a valid flag. The block next counts a fixed run of sixteen control clocks. After the last of these it raises a program request, which tells external circuitry to apply the high-voltage write step. The request and the fields hold steady until enable drops. When enable drops, the port clears itself and is ready for the next command. The activation input is held between commands.

All port inputs pass through a synchroniser of parameter depth into the system clock domain. Edges of the test clock are detected in that domain.

Top module: `stm_prog_port`

## Requirements
- R1: After reset, prog_req and fld_valid are 0, and wr_data, row_addr and nib_addr are all zero.
- R2: The command code is 6 bits wide and is sent least significant bit first. Only code 0x04 starts a write sequence.
- R3: The 4 bits that follow the code are sent least significant bit first. They appear on wr_data.
- R4: After the data, the port takes a 4-bit row address and then a 2-bit nibble address, each least significant bit first. They appear on row_addr and nib_addr. fld_valid goes to 1 once the last nibble-address bit has been taken.
- R5: prog_req stays 0 through the first 15 control clocks after the address fields. It goes to 1 only after the 16th control clock.
- R6: While prog_req is 1, further test clocks and data values do not change prog_req, wr_data, row_addr or nib_addr.
- R7: When enable goes low, prog_req, fld_valid and all field outputs clear to zero. A following command is then received normally.
- R8: After any code other than 0x04, fld_valid and prog_req stay 0 whatever clocks arrive, until enable goes low. This includes codes that differ from 0x04 only in bit 5.
- R9: While the activation input is low, the port takes no bits. fld_valid and prog_req stay 0.
- R10: A bit is taken on the rising test-clock edge only. A change on the data line while the test clock is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Activation; the port works only while high |
| ten | input | 1 | Port enable; a falling level clears the port |
| tclk | input | 1 | Serial test clock; bits are taken on its rising edge |
| tdat | input | 1 | Serial data, least significant bit first |
| prog_req | output | 1 | Request for the external write step |
| fld_valid | output | 1 | All address and data fields captured |
| wr_data | output | 4 | Data nibble to write |
| row_addr | output | 4 | Row address |
| nib_addr | output | 2 | Nibble address within the row |

## Verification
The bench builds the block with its default parameters: a 6-bit code, fields of 4, 4 and 2 bits, 16 control clocks and a two-stage synchroniser. This makes the full decode of code 0x04 testable, including a code that differs only in the top bit. It also makes the edge rows 0 and 15 and every nibble address testable. The exact 15-versus-16 boundary of the control phase can be checked. Because the synchroniser delays data and clock by the same amount, a data change while the test clock is high lands after the sampled edge. This makes the R10 check meaningful.

// File: rtl/stm_pkg.sv
package stm_pkg;
   typedef enum logic [2:0] {
      ST_CODE  = 3'd0,
      ST_DATA  = 3'd1,
      ST_ROW   = 3'd2,
      ST_NIB   = 3'd3,
      ST_CTRL  = 3'd4,
      ST_READY = 3'd5,
      ST_SKIP  = 3'd6
   } stm_state_e;
endpackage

// File: rtl/stm_sync.sv
module stm_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [W-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
         end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/stm_seq_ctrl.sv
module stm_seq_ctrl
   import stm_pkg::*;
#(
   parameter int MODE_W    = 6,
   parameter int DATA_W    = 4,
   parameter int ROW_W     = 4,
   parameter int NIB_W     = 2,
   parameter int CTRL_CLKS = 16,
   parameter int PROG_MODE = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active,
   input  logic       rise,
   input  logic       sbit,
   output stm_state_e state
);
   localparam int M1    = (MODE_W > DATA_W) ? MODE_W : DATA_W;
   localparam int M2    = (ROW_W > NIB_W) ? ROW_W : NIB_W;
   localparam int M3    = (M1 > M2) ? M1 : M2;
   localparam int MAXF  = (M3 > CTRL_CLKS) ? M3 : CTRL_CLKS;
   localparam int CNT_W = $clog2(MAXF + 1);

   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  last;
   logic [MODE_W-1:0] code_sr;
   logic [MODE_W-1:0] code_nxt;
   stm_state_e        next_st;

   assign code_nxt = {sbit, code_sr[MODE_W-1:1]};

   always_comb begin
      last    = '0;
      next_st = state;
      case (state)
         ST_CODE: begin
            last    = CNT_W'(MODE_W - 1);
            next_st = (code_nxt == MODE_W'(PROG_MODE)) ? ST_DATA : ST_SKIP;
         end
         ST_DATA: begin last = CNT_W'(DATA_W - 1);    next_st = ST_ROW;   end
         ST_ROW:  begin last = CNT_W'(ROW_W - 1);     next_st = ST_NIB;   end
         ST_NIB:  begin last = CNT_W'(NIB_W - 1);     next_st = ST_CTRL;  end
         ST_CTRL: begin last = CNT_W'(CTRL_CLKS - 1); next_st = ST_READY; end
         default: begin last = '0;                    next_st = state;    end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_CODE;
         cnt     <= '0;
         code_sr <= '0;
      end else if (!active) begin
         state   <= ST_CODE;
         cnt     <= '0;
         code_sr <= '0;
      end else if (rise && state != ST_READY && state != ST_SKIP) begin
         if (state == ST_CODE) code_sr <= code_nxt;
         if (cnt == last) begin
            cnt   <= '0;
            state <= next_st;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R5: the request state is entered only from the last control clock
   assert_ready_after_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READY && $past(state) != ST_READY) |->
         ($past(state) == ST_CTRL && $past(cnt) == CNT_W'(CTRL_CLKS - 1)));

   // R8: a rejected code never leads into field capture
   assert_skip_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_SKIP |=> (state == ST_SKIP || state == ST_CODE));
endmodule

// File: rtl/stm_field_cap.sv
module stm_field_cap
   import stm_pkg::*;
#(
   parameter int DATA_W = 4,
   parameter int ROW_W  = 4,
   parameter int NIB_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              rise,
   input  logic              sbit,
   input  stm_state_e        state,
   output logic [DATA_W-1:0] wr_data,
   output logic [ROW_W-1:0]  row_addr,
   output logic [NIB_W-1:0]  nib_addr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_data  <= '0;
         row_addr <= '0;
         nib_addr <= '0;
      end else if (!active) begin
         wr_data  <= '0;
         row_addr <= '0;
         nib_addr <= '0;
      end else if (rise) begin
         case (state)
            ST_DATA: wr_data  <= {sbit, wr_data[DATA_W-1:1]};
            ST_ROW:  row_addr <= {sbit, row_addr[ROW_W-1:1]};
            ST_NIB:  nib_addr <= {sbit, nib_addr[NIB_W-1:1]};
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/stm_prog_port.sv
module stm_prog_port
   import stm_pkg::*;
#(
   parameter int MODE_W      = 6,
   parameter int DATA_W      = 4,
   parameter int ROW_W       = 4,
   parameter int NIB_W       = 2,
   parameter int CTRL_CLKS   = 16,
   parameter int PROG_MODE   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic              ten,
   input  logic              tclk,
   input  logic              tdat,
   output logic              prog_req,
   output logic              fld_valid,
   output logic [DATA_W-1:0] wr_data,
   output logic [ROW_W-1:0]  row_addr,
   output logic [NIB_W-1:0]  nib_addr
);
   if (MODE_W < 2 || DATA_W < 2 || ROW_W < 2 || NIB_W < 2) begin : g_bad_width
      $error("stm_prog_port: every field must be at least 2 bits wide");
   end
   if (CTRL_CLKS < 1) begin : g_bad_ctrl
      $error("stm_prog_port: CTRL_CLKS must be at least 1");
   end
   if (PROG_MODE < 0 || PROG_MODE >= (1 << MODE_W)) begin : g_bad_code
      $error("stm_prog_port: PROG_MODE does not fit in MODE_W bits");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("stm_prog_port: SYNC_STAGES must lie in 0..4");
   end

   logic [3:0] raw_in, sync_out;
   logic       arm_s, ten_s, tclk_s, tdat_s, tclk_q, rise, active;
   stm_state_e state;

   assign raw_in = {arm, ten, tclk, tdat};

   stm_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
   );

   assign {arm_s, ten_s, tclk_s, tdat_s} = sync_out;
   assign active = arm_s & ten_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tclk_q <= 1'b0;
      else        tclk_q <= tclk_s;
   end
   assign rise = tclk_s & ~tclk_q;

   stm_seq_ctrl #(
      .MODE_W(MODE_W), .DATA_W(DATA_W), .ROW_W(ROW_W), .NIB_W(NIB_W),
      .CTRL_CLKS(CTRL_CLKS), .PROG_MODE(PROG_MODE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .active(active), .rise(rise),
      .sbit(tdat_s), .state(state)
   );

   stm_field_cap #(.DATA_W(DATA_W), .ROW_W(ROW_W), .NIB_W(NIB_W)) u_fields (
      .clk(clk), .rst_n(rst_n), .active(active), .rise(rise), .sbit(tdat_s),
      .state(state), .wr_data(wr_data), .row_addr(row_addr), .nib_addr(nib_addr)
   );

   assign fld_valid = (state == ST_CTRL) || (state == ST_READY);
   assign prog_req  = (state == ST_READY);

   // R4: a request is never raised without captured fields
   assert_req_has_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |-> fld_valid);

   // R6: fields hold while the request stays up
   assert_fields_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req && $past(prog_req)) |->
         ($stable(wr_data) && $stable(row_addr) && $stable(nib_addr)));

   // R7: a low enable clears the port on the next cycle
   assert_enable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ten_s |=> (!fld_valid && !prog_req && wr_data == '0));

   // R9: without activation nothing is captured
   assert_idle_unarmed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_s |=> (!fld_valid && row_addr == '0));
endmodule

// File: tb/stm_prog_port_tb.sv
module stm_prog_port_tb;
   typedef struct packed {
      logic [3:0] data;
      logic [3:0] row;
      logic [1:0] nib;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0, ten = 1'b0, tclk = 1'b0, tdat = 1'b0;
   logic prog_req, fld_valid;
   logic [3:0] wr_data, row_addr;
   logic [1:0] nib_addr;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t expq[$];
   logic req_prev = 1'b0;

   always #5 clk = ~clk;

   stm_prog_port u_dut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .ten(ten), .tclk(tclk), .tdat(tdat),
      .prog_req(prog_req), .fld_valid(fld_valid), .wr_data(wr_data),
      .row_addr(row_addr), .nib_addr(nib_addr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input bit glitch);
      tdat = b;
      wait_clk(4);
      tclk = 1'b1;
      wait_clk(2);
      if (glitch) tdat = ~b;
      wait_clk(2);
      tclk = 1'b0;
   endtask

   task automatic send_field(input int val, input int w, input bit glitch);
      for (int i = 0; i < w; i++) send_bit(val[i], glitch);
   endtask

   task automatic send_cmd(input int code, input int d, input int r, input int n,
                           input bit glitch);
      ten = 1'b1;
      wait_clk(4);
      send_field(code, 6, glitch);
      send_field(d, 4, glitch);
      send_field(r, 4, glitch);
      send_field(n, 2, glitch);
   endtask

   task automatic drop_enable();
      ten = 1'b0;
      wait_clk(8);
   endtask

   // full write: push expectation, 16 control clocks, then check request
   task automatic full_write(input int d, input int r, input int n, input bit glitch,
                             input string req);
      exp_t e;
      e.data = 4'(d); e.row = 4'(r); e.nib = 2'(n);
      send_cmd(4, d, r, n, glitch);
      expq.push_back(e);
      for (int i = 0; i < 16; i++) send_bit(1'(i), 1'b0);
      wait_clk(6);
      chk(prog_req === 1'b1, req, "prog_req after 16 control clocks", prog_req, 1);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && prog_req === 1'b1 && req_prev === 1'b0) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R5", "unexpected prog_req", 1, 0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            chk(wr_data === e.data, "R3", "wr_data at request", wr_data, e.data);
            chk(row_addr === e.row, "R4", "row_addr at request", row_addr, e.row);
            chk(nib_addr === e.nib, "R4", "nib_addr at request", nib_addr, e.nib);
         end
      end
      req_prev = prog_req;
   end

   initial begin
      wait_clk(3);
      chk(prog_req === 1'b0 && fld_valid === 1'b0, "R1", "flags in reset",
          {prog_req, fld_valid}, 0);
      rst_n = 1'b1;
      wait_clk(3);
      chk(wr_data === 4'h0 && row_addr === 4'h0 && nib_addr === 2'h0, "R1",
          "fields after reset", {wr_data, row_addr, nib_addr}, 0);
      arm = 1'b1;
      wait_clk(4);

      // first write, checking the 15/16 control-clock boundary
      send_cmd(4, 'hA, 'h5, 2, 1'b0);
      wait_clk(6);
      chk(fld_valid === 1'b1, "R4", "fld_valid after address", fld_valid, 1);
      chk(wr_data === 4'hA, "R3", "wr_data captured", wr_data, 'hA);
      chk(row_addr === 4'h5 && nib_addr === 2'h2, "R4", "row/nib captured",
          {row_addr, nib_addr}, {4'h5, 2'h2});
      for (int i = 0; i < 15; i++) send_bit(1'b1, 1'b0);
      wait_clk(6);
      chk(prog_req === 1'b0, "R5", "prog_req after 15 control clocks", prog_req, 0);
      expq.push_back('{data: 4'hA, row: 4'h5, nib: 2'h2});
      send_bit(1'b0, 1'b0);
      wait_clk(6);
      chk(prog_req === 1'b1, "R5", "prog_req after 16th control clock", prog_req, 1);
      for (int i = 0; i < 7; i++) send_bit(1'(i * 3), 1'b0);
      wait_clk(6);
      chk(prog_req === 1'b1 && wr_data === 4'hA && row_addr === 4'h5 &&
          nib_addr === 2'h2, "R6", "outputs under extra clocks",
          {prog_req, wr_data, row_addr, nib_addr}, {1'b1, 4'hA, 4'h5, 2'h2});
      drop_enable();
      chk(prog_req === 1'b0 && fld_valid === 1'b0, "R7", "flags after enable low",
          {prog_req, fld_valid}, 0);
      chk(wr_data === 4'h0 && row_addr === 4'h0 && nib_addr === 2'h0, "R7",
          "fields after enable low", {wr_data, row_addr, nib_addr}, 0);

      // following commands: edge addresses
      full_write('h3, 'hF, 3, 1'b0, "R7");
      drop_enable();
      full_write('h0, 'h0, 0, 1'b0, "R2");
      drop_enable();

      // data changes while test clock is high
      full_write('h6, 'h9, 1, 1'b1, "R10");
      chk(wr_data === 4'h6 && row_addr === 4'h9 && nib_addr === 2'h1, "R10",
          "fields with high-phase data changes", {wr_data, row_addr, nib_addr},
          {4'h6, 4'h9, 2'h1});
      drop_enable();

      // rejected codes
      send_cmd('h05, 'hF, 'hF, 3, 1'b0);
      for (int i = 0; i < 20; i++) send_bit(1'b1, 1'b0);
      wait_clk(6);
      chk(fld_valid === 1'b0 && prog_req === 1'b0, "R8", "code 0x05 ignored",
          {fld_valid, prog_req}, 0);
      drop_enable();
      send_cmd('h24, 'h1, 'h2, 1, 1'b0);
      for (int i = 0; i < 20; i++) send_bit(1'b0, 1'b0);
      wait_clk(6);
      chk(fld_valid === 1'b0 && prog_req === 1'b0, "R8", "code 0x24 ignored",
          {fld_valid, prog_req}, 0);
      drop_enable();

      // activation low
      arm = 1'b0;
      wait_clk(4);
      send_cmd(4, 'h7, 'h7, 2, 1'b0);
      for (int i = 0; i < 16; i++) send_bit(1'b1, 1'b0);
      wait_clk(6);
      chk(fld_valid === 1'b0 && prog_req === 1'b0 && wr_data === 4'h0, "R9",
          "no capture while unarmed", {fld_valid, prog_req, wr_data}, 0);
      drop_enable();
      arm = 1'b1;
      wait_clk(4);

      full_write('hC, 'h1, 2, 1'b0, "R2");
      drop_enable();

      chk(expq.size() == 0, "R3", "scoreboard drained", expq.size(), 0);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #1500000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule